// File: doc/BRIEF.md
# Four-Channel Bank Access Arbiter

This block sits in front of a single memory bank and decides which of four requesters may use it. The bank is shared by two ports, a wide port that carries processor traffic and a narrow port that carries DMA traffic. Each port has a read channel and a write channel. When more than one channel asks for the bank, a fixed order picks the winner. Any channel that also raises its urgent line moves ahead of every channel that does not. The winner keeps the bank for a whole burst, and releases it when it marks the final beat.

A configuration input marks the bank as read-only. While that input is set, write channels are not eligible for arbitration. Each cycle that holds a write request is answered one cycle later with a one-cycle error pulse on that channel, and no grant is given for it. Data paths and the storage array are outside this block.

The control is a two-state machine.
- `ST_IDLE`: the bank is free. On the `win` transition it moves to `ST_OWNED` and registers the one-hot winner. This happens when at least one eligible request is present.
- `ST_OWNED`: `hold` keeps the owner while the owner's last-beat line is low. The `release` transition returns to `ST_IDLE` when the owner's last-beat line is sampled high.
- `wait`: the machine stays in `ST_IDLE` when no eligible request is present.

Top module: `bank_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `grant` and `err` are all zero.
- R2: Channel bit positions are 0 = port 0 read, 1 = port 0 write, 2 = port 1 read and 3 = port 1 write. Among eligible non-urgent requests, the lowest bit index wins. The grant appears in the cycle after the requests are sampled in `ST_IDLE`.
- R3: If any eligible request has its urgent bit set, the winner is one of the urgent requesters, even when a lower-index non-urgent request is present.
- R4: Among several eligible urgent requesters, the lowest bit index wins.
- R5: `grant` is one-hot or zero in every cycle.
- R6: Once a channel is granted, the grant stays on that channel until its `last` bit is sampled high. New, urgent or higher-priority requests do not change the grant meanwhile.
- R7: After the owner's `last` is sampled, `grant` is zero in the next cycle. Pending requests are then arbitrated and granted one cycle later.
- R8: With `rom_mode` = 1, write channels (bits 1 and 3) are never granted, even when urgent. Read channels arbitrate normally.
- R9: With `rom_mode` = 1, each cycle a write request is present produces a one-cycle pulse on that channel's `err` bit in the next cycle. With `rom_mode` = 0, `err` stays zero.
- R10: An urgent bit on a channel that is not requesting has no effect on the choice of winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_mode | input | 1 | 1 = bank is read-only |
| req | input | 4 | Per-channel request |
| urgent | input | 4 | Per-channel priority elevation |
| last | input | 4 | Per-channel final-beat marker |
| grant | output | 4 | One-hot bank grant |
| err | output | 4 | Per-channel write-to-read-only error pulse |

## Verification
Two functions can fall in the same cycle: a write is refused while a read wins arbitration. In that cycle an `err` pulse and a `grant` rise together on different bits. The bench provokes this by driving read and write requests at once with `rom_mode` set, including a write that is also urgent. It then checks that the grant lands on the read channel while the error lands only on the write bits, with both values taken one cycle after the request. A second overlap comes from urgent requests arriving during a held burst. There the bench checks that the grant stays fixed until the owner's last beat, and that it moves to the urgent channel only after a free cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } arb_state_e;

    // Channels alternate read/write per port: odd indices are writes.
    function automatic logic [63:0] odd_bits(input int n);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if ((i % 2 == 1) && (i < n)) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int unsigned NCH = 4
) (
    input  logic [NCH-1:0] cand,
    output logic [NCH-1:0] win,
    output logic           any
);
    logic found;

    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (cand[i] && !found) begin
                win[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign any = |cand;

endmodule

// File: rtl/arb_rom_gate.sv
module arb_rom_gate #(
    parameter int unsigned    NCH     = 4,
    parameter logic [NCH-1:0] WR_MASK = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rom_mode,
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] eligible,
    output logic [NCH-1:0] err
);
    logic [NCH-1:0] blocked;

    assign blocked  = rom_mode ? WR_MASK : '0;
    assign eligible = req & ~blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err <= '0;
        else        err <= req & blocked;
    end

endmodule

// File: rtl/bank_arbiter.sv
module bank_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rom_mode,
    input  logic [2*NUM_PORTS-1:0] req,
    input  logic [2*NUM_PORTS-1:0] urgent,
    input  logic [2*NUM_PORTS-1:0] last,
    output logic [2*NUM_PORTS-1:0] grant,
    output logic [2*NUM_PORTS-1:0] err
);
    localparam int unsigned    NCH     = 2 * NUM_PORTS;
    localparam logic [63:0]    WR_ALL  = odd_bits(NCH);
    localparam logic [NCH-1:0] WR_MASK = WR_ALL[NCH-1:0];

    arb_state_e     state, state_nx;
    logic [NCH-1:0] owner, owner_nx;
    logic [NCH-1:0] eligible;
    logic [NCH-1:0] win_u, win_n, winner;
    logic           any_u, any_n;

    arb_rom_gate #(.NCH(NCH), .WR_MASK(WR_MASK)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_mode (rom_mode),
        .req      (req),
        .eligible (eligible),
        .err      (err)
    );

    arb_pick #(.NCH(NCH)) u_pick_urgent (
        .cand (eligible & urgent),
        .win  (win_u),
        .any  (any_u)
    );

    arb_pick #(.NCH(NCH)) u_pick_base (
        .cand (eligible),
        .win  (win_n),
        .any  (any_n)
    );

    assign winner = any_u ? win_u : win_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            owner <= '0;
        end else begin
            state <= state_nx;
            owner <= owner_nx;
        end
    end

    // Transitions: win, wait, hold, release
    always_comb begin
        state_nx = state;
        owner_nx = owner;
        unique case (state)
            ST_IDLE: begin
                if (any_n) begin
                    state_nx = ST_OWNED;
                    owner_nx = winner;
                end
            end
            ST_OWNED: begin
                if (|(owner & last)) begin
                    state_nx = ST_IDLE;
                    owner_nx = '0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                owner_nx = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_OWNED: grant = owner;
            default:  grant = '0;
        endcase
    end

endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rom_mode,
    input logic [NCH-1:0] req,
    input logic [NCH-1:0] urgent,
    input logic [NCH-1:0] last,
    input logic [NCH-1:0] grant,
    input logic [NCH-1:0] err
);
    localparam logic [63:0]    WR_ALL  = odd_bits(NCH);
    localparam logic [NCH-1:0] WR_MASK = WR_ALL[NCH-1:0];

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r6_hold_owner: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((grant != '0) && ((grant & last) == '0)) |=> (grant == $past(grant)));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((grant & last) != '0) |=> (grant == '0));

    a_r8_no_rom_write_grant: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (((grant & ~$past(grant) & WR_MASK) != '0)) |-> !$past(rom_mode));

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(rom_mode) |-> (err == ($past(req) & WR_MASK)));

    a_r9_no_err_ram: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(rom_mode) |-> (err == '0));

    a_r3_urgent_wins: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((grant != '0) && ($past(grant) == '0) &&
         ($past(urgent & req & ~(rom_mode ? WR_MASK : '0)) != '0))
        |-> ((grant & $past(urgent)) != '0));

endmodule

bind bank_arbiter arb_checker #(.NCH(2 * NUM_PORTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_mode (rom_mode),
    .req      (req),
    .urgent   (urgent),
    .last     (last),
    .grant    (grant),
    .err      (err)
);

// File: tb/bank_arbiter_tb.sv
`timescale 1ns/1ps
module bank_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rom_mode = 1'b0;
    logic [3:0] req = '0, urgent = '0, last = '0;
    logic [3:0] grant, err;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bank_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .rom_mode(rom_mode),
        .req(req), .urgent(urgent), .last(last),
        .grant(grant), .err(err)
    );

    // {rom, req, urgent, expected grant, expected err}
    localparam logic [16:0] VEC [14] = '{
        17'b0_1111_0000_0001_0000, // R2
        17'b0_1110_0000_0010_0000, // R2
        17'b0_1100_0000_0100_0000, // R2
        17'b0_1000_0000_1000_0000, // R2
        17'b0_1111_1000_1000_0000, // R3
        17'b0_0111_0100_0100_0000, // R3
        17'b0_1111_1010_0010_0000, // R4
        17'b0_1100_1100_0100_0000, // R4
        17'b0_0011_1100_0001_0000, // R10
        17'b1_1111_0000_0001_1010, // R8 R9
        17'b1_1010_0000_0000_1010, // R9
        17'b1_1110_0010_0100_1010, // R8
        17'b1_1000_1000_0000_1000, // R9
        17'b0_1010_0000_0010_0000  // R9
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
        n_checks++;
        if (!$onehot0(grant)) begin
            n_fail++;
            $display("FAIL R5 grant one-hot: actual %b expected one-hot or zero", grant);
        end
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 grant in reset", grant, 4'b0000);
        check("R1 err in reset", err, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grant after reset", grant, 4'b0000);
        check("R1 err after reset", err, 4'b0000);

        foreach (VEC[i]) begin
            rom_mode = VEC[i][16];
            req      = VEC[i][15:12];
            urgent   = VEC[i][11:8];
            last     = 4'b0000;
            @(negedge clk);
            check($sformatf("table %0d grant (R2 R3 R4 R8 R10)", i), grant, VEC[i][7:4]);
            check($sformatf("table %0d err (R9)", i), err, VEC[i][3:0]);
            req = '0; urgent = '0; last = 4'b1111;
            @(negedge clk);
            check($sformatf("table %0d grant released (R7)", i), grant, 4'b0000);
            check($sformatf("table %0d err pulse ended (R9)", i), err, 4'b0000);
            last = '0; rom_mode = 1'b0;
        end

        // Burst hold against urgent competition
        req = 4'b0001;
        @(negedge clk);
        check("R6 burst start", grant, 4'b0001);
        req = 4'b1001; urgent = 4'b1000;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 burst held", grant, 4'b0001);
        end
        last = 4'b1000;
        @(negedge clk);
        check("R6 non-owner last ignored", grant, 4'b0001);
        last = 4'b0001;
        @(negedge clk);
        check("R7 drop after last", grant, 4'b0000);
        req = 4'b1000; last = 4'b0000;
        @(negedge clk);
        check("R7 rearbitrate to urgent", grant, 4'b1000);
        req = '0; urgent = '0; last = 4'b1000;
        @(negedge clk);
        check("R7 second release", grant, 4'b0000);
        last = '0;

        // Read-only error pulse width, overlapping a read grant
        rom_mode = 1'b1; req = 4'b1100; urgent = 4'b1000;
        @(negedge clk);
        check("R8 read wins over urgent write", grant, 4'b0100);
        check("R9 err on write", err, 4'b1000);
        req = 4'b0000; urgent = '0;
        @(negedge clk);
        check("R9 single-cycle pulse", err, 4'b0000);
        check("R6 read burst held", grant, 4'b0100);
        last = 4'b0100;
        @(negedge clk);
        check("R7 read released", grant, 4'b0000);
        last = '0; rom_mode = 1'b0;
        @(negedge clk);
        check("R9 no err in RAM mode", err, 4'b0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule